// File: doc/BRIEF.md
# Address-Sequence Command Detector

This block snoops read traffic from a host on an asynchronous-style memory bus. It turns one specific run of six consecutive reads into a command pulse. The first five addresses of the run form a fixed unlock key. The sixth address chooses one of four commands:

- save to non-volatile storage
- restore from non-volatile storage
- switch automatic saving off
- switch automatic saving on

The host issues commands with ordinary reads, so no extra pins or registers are needed. A write, or a read at an unexpected address, cancels a partial run.

The bus pins are already synchronous to `clk`. The detector registers them, finds the start of each read, and compares the lower 16 address bits against the expected entry. When a run completes it raises exactly one command output for one clock. The block also holds the automatic-save enable bit. That bit resets to enabled and follows the on/off commands. Saving the bit across power loss is the job of a later save command, which a separate sequencer carries out. While that sequencer reports busy, the detector freezes and ignores the bus. All interfaces are plain control pins. No data stream passes through the block, so it has no valid/ready handshake.

Top module: `cmd_seq_detect`

## Requirements
- R1: After reset all four command outputs are low, `auto_store_en` is 1 and the detector is idle.
- R2: Five reads at 0x4E38, 0xB1C7, 0x83E0, 0x7C1F, 0x703F in that order, followed by a read at 0x8FC0, raise `store_pls` for one cycle. The pulse is high in the second clock cycle after the clock edge that first samples the sixth read active.
- R3: The key followed by a read at 0x4C63 raises `recall_pls` once.
- R4: The key followed by 0x8B45 raises `auto_off_pls` and clears `auto_store_en` on the same edge. The key followed by 0x4B46 raises `auto_on_pls` and sets `auto_store_en`.
- R5: Only address bits 15:0 are compared. Bit 16 has no effect on matching.
- R6: A write cycle (`bus_ce_n`=0, `bus_we_n`=0) during a partial run returns the detector to idle, so the rest of that run issues nothing.
- R7: A read is active when `bus_ce_n`=0, `bus_oe_n`=0 and `bus_we_n`=1. Each read counts as one step, taken when it becomes active, whichever of the two enables falls last. A read held active for many cycles still counts once.
- R8: A read at an address other than the expected next one returns to idle. If that address is the first key address (0x4E38), the detector moves to step one instead.
- R9: While `seq_busy`=1, reads and writes are ignored and the partial run is kept.
- R10: After the sixth read, whether it matched a command or not, the detector is idle again. A wrong sixth address issues nothing.
- R11: At most one command output is high in any cycle, and no pulse lasts more than one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | ADDR_W (17) | Host address bus |
| bus_ce_n | input | 1 | Chip enable, active low |
| bus_oe_n | input | 1 | Output enable, active low |
| bus_we_n | input | 1 | Write enable, active low |
| seq_busy | input | 1 | Command sequencer busy; freezes the detector |
| store_pls | output | 1 | Save command pulse |
| recall_pls | output | 1 | Restore command pulse |
| auto_off_pls | output | 1 | Automatic-save disable pulse |
| auto_on_pls | output | 1 | Automatic-save enable pulse |
| auto_store_en | output | 1 | Automatic-save enable bit |

## Verification
A wrong step counter shows up only at the end of a run. The symptoms are a missing pulse, a pulse after a foreign read or a write, or a pulse after a restarted key. The directed runs therefore end each scenario with a sixth read and compare pulse counts two cycles later. Double counting of a long read is exposed by stretching a middle key read: if it were counted twice, the run would break. Latency and pulse width are checked cycle by cycle on one run. The enable bit is compared right after each on/off command.

// File: rtl/cmd_seq_pkg.sv
package cmd_seq_pkg;
  localparam int CMP_W   = 16;
  localparam int KEY_LEN = 5;
  localparam int NUM_CMD = 4;

  typedef enum logic [1:0] {
    CMD_STORE    = 2'd0,
    CMD_RECALL   = 2'd1,
    CMD_AUTO_OFF = 2'd2,
    CMD_AUTO_ON  = 2'd3
  } cmd_e;

  // Unlock key, in required order
  function automatic logic [CMP_W-1:0] key_word(input int unsigned idx);
    case (idx)
      0:       key_word = 16'h4E38;
      1:       key_word = 16'hB1C7;
      2:       key_word = 16'h83E0;
      3:       key_word = 16'h7C1F;
      default: key_word = 16'h703F;
    endcase
  endfunction

  // Sixth address per command, indexed by cmd_e
  function automatic logic [CMP_W-1:0] cmd_word(input int unsigned idx);
    case (idx)
      0:       cmd_word = 16'h8FC0;
      1:       cmd_word = 16'h4C63;
      2:       cmd_word = 16'h8B45;
      default: cmd_word = 16'h4B46;
    endcase
  endfunction
endpackage

// File: rtl/bus_strobe.sv
module bus_strobe #(
  parameter int ADDR_W = 17,
  parameter int CMP_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  output logic              rd_stb,
  output logic              wr_act,
  output logic [CMP_W-1:0]  cap_addr
);
  logic rd_now, rd_prev;

  assign rd_now = ~ce_n & ~oe_n & we_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_prev  <= 1'b0;
      rd_stb   <= 1'b0;
      wr_act   <= 1'b0;
      cap_addr <= '0;
    end else begin
      rd_prev  <= rd_now;
      rd_stb   <= rd_now & ~rd_prev;
      wr_act   <= ~ce_n & ~we_n;
      cap_addr <= addr[CMP_W-1:0];
    end
  end

  // R7
  strobe_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb |=> !rd_stb);
endmodule

// File: rtl/key_matcher.sv
module key_matcher
  import cmd_seq_pkg::*;
(
  input  logic [CMP_W-1:0]   word,
  output logic [KEY_LEN-1:0] key_hit,
  output logic [NUM_CMD-1:0] cmd_hit
);
  for (genvar k = 0; k < KEY_LEN; k++) begin : g_key
    assign key_hit[k] = (word == key_word(k));
  end
  for (genvar c = 0; c < NUM_CMD; c++) begin : g_cmd
    assign cmd_hit[c] = (word == cmd_word(c));
  end
endmodule

// File: rtl/seq_fsm.sv
module seq_fsm
  import cmd_seq_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               busy,
  input  logic               rd_stb,
  input  logic               wr_act,
  input  logic [KEY_LEN-1:0] key_hit,
  input  logic [NUM_CMD-1:0] cmd_hit,
  output logic [NUM_CMD-1:0] cmd_pls,
  output logic               auto_en
);
  localparam int STEP_W = $clog2(KEY_LEN + 1);
  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(KEY_LEN);

  logic [STEP_W-1:0]  step, step_nxt;
  logic [NUM_CMD-1:0] pls_nxt;
  logic               auto_nxt;
  logic [STEP_W-1:0]  restart;

  assign restart = key_hit[0] ? STEP_W'(1) : '0;

  always_comb begin
    step_nxt = step;
    pls_nxt  = '0;
    auto_nxt = auto_en;
    if (!busy) begin
      if (wr_act) begin
        step_nxt = '0;
      end else if (rd_stb) begin
        if (step < LAST_STEP) begin
          if (key_hit[step]) step_nxt = step + 1'b1;
          else               step_nxt = restart;
        end else begin
          pls_nxt  = cmd_hit;
          step_nxt = restart;
          if (cmd_hit[CMD_AUTO_OFF]) auto_nxt = 1'b0;
          if (cmd_hit[CMD_AUTO_ON])  auto_nxt = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step    <= '0;
      cmd_pls <= '0;
      auto_en <= 1'b1;
    end else begin
      step    <= step_nxt;
      cmd_pls <= pls_nxt;
      auto_en <= auto_nxt;
    end
  end

  // R11
  pulse_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cmd_pls));
  // R11
  pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|cmd_pls) |=> !(|cmd_pls));
  // R6
  write_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_act && !busy) |=> (step == '0));
  // R9
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(step) && $stable(auto_en) && !(|cmd_pls)));
  // R10
  cmd_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|cmd_pls) |-> (step <= STEP_W'(1)));
  // R4
  autoen_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(auto_en) |-> cmd_pls[CMD_AUTO_OFF]);
endmodule

// File: rtl/cmd_seq_detect.sv
module cmd_seq_detect
  import cmd_seq_pkg::*;
#(
  parameter int ADDR_W = 17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_ce_n,
  input  logic              bus_oe_n,
  input  logic              bus_we_n,
  input  logic              seq_busy,
  output logic              store_pls,
  output logic              recall_pls,
  output logic              auto_off_pls,
  output logic              auto_on_pls,
  output logic              auto_store_en
);
  logic               rd_stb, wr_act;
  logic [CMP_W-1:0]   cap_addr;
  logic [KEY_LEN-1:0] key_hit;
  logic [NUM_CMD-1:0] cmd_hit, cmd_pls;

  bus_strobe #(.ADDR_W(ADDR_W), .CMP_W(CMP_W)) u_strobe (
    .clk(clk), .rst_n(rst_n), .addr(bus_addr),
    .ce_n(bus_ce_n), .oe_n(bus_oe_n), .we_n(bus_we_n),
    .rd_stb(rd_stb), .wr_act(wr_act), .cap_addr(cap_addr)
  );

  key_matcher u_match (
    .word(cap_addr), .key_hit(key_hit), .cmd_hit(cmd_hit)
  );

  seq_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .busy(seq_busy),
    .rd_stb(rd_stb), .wr_act(wr_act),
    .key_hit(key_hit), .cmd_hit(cmd_hit),
    .cmd_pls(cmd_pls), .auto_en(auto_store_en)
  );

  assign store_pls    = cmd_pls[CMD_STORE];
  assign recall_pls   = cmd_pls[CMD_RECALL];
  assign auto_off_pls = cmd_pls[CMD_AUTO_OFF];
  assign auto_on_pls  = cmd_pls[CMD_AUTO_ON];

  // R1
  reset_state_chk: assert property (@(posedge clk)
    $rose(rst_n) |-> (auto_store_en && !store_pls && !recall_pls));
endmodule

// File: tb/cmd_seq_detect_tb.sv
module cmd_seq_detect_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [16:0] bus_addr = '0;
  logic        bus_ce_n = 1'b1, bus_oe_n = 1'b1, bus_we_n = 1'b1;
  logic        seq_busy = 1'b0;
  logic        store_pls, recall_pls, auto_off_pls, auto_on_pls, auto_store_en;

  int n_chk = 0, n_fail = 0;
  int c_st = 0, c_rc = 0, c_off = 0, c_on = 0, c_multi = 0;
  int s_st, s_rc, s_off, s_on;

  logic [15:0] key [5] = '{16'h4E38, 16'hB1C7, 16'h83E0, 16'h7C1F, 16'h703F};
  localparam logic [15:0] A_ST = 16'h8FC0, A_RC = 16'h4C63,
                          A_OFF = 16'h8B45, A_ON = 16'h4B46;

  always #(CLK_PERIOD/2) clk = ~clk;

  cmd_seq_detect dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr),
    .bus_ce_n(bus_ce_n), .bus_oe_n(bus_oe_n), .bus_we_n(bus_we_n),
    .seq_busy(seq_busy), .store_pls(store_pls), .recall_pls(recall_pls),
    .auto_off_pls(auto_off_pls), .auto_on_pls(auto_on_pls),
    .auto_store_en(auto_store_en)
  );

  always @(negedge clk) if (rst_n) begin
    c_st  += int'(store_pls);
    c_rc  += int'(recall_pls);
    c_off += int'(auto_off_pls);
    c_on  += int'(auto_on_pls);
    if (int'(store_pls) + int'(recall_pls) + int'(auto_off_pls) + int'(auto_on_pls) > 1)
      c_multi++;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic snap();
    s_st = c_st; s_rc = c_rc; s_off = c_off; s_on = c_on;
  endtask

  task automatic expect_cnt(input string tag, input int es, input int er,
                            input int eoff, input int eon);
    repeat (3) @(negedge clk);
    chk(c_st - s_st == es,    {tag, " store"},    c_st - s_st, es);
    chk(c_rc - s_rc == er,    {tag, " recall"},   c_rc - s_rc, er);
    chk(c_off - s_off == eoff, {tag, " auto_off"}, c_off - s_off, eoff);
    chk(c_on - s_on == eon,   {tag, " auto_on"},  c_on - s_on, eon);
  endtask

  // chip-enable controlled read (both enables fall together)
  task automatic rd(input logic [16:0] a, input int hold = 2);
    @(negedge clk);
    bus_addr = a; bus_we_n = 1'b1; bus_ce_n = 1'b0; bus_oe_n = 1'b0;
    repeat (hold) @(negedge clk);
    bus_ce_n = 1'b1; bus_oe_n = 1'b1;
    @(negedge clk);
  endtask

  // output-enable controlled read: chip enable already low
  task automatic rd_oe(input logic [16:0] a, input int hold = 2);
    @(negedge clk);
    bus_addr = a; bus_we_n = 1'b1; bus_ce_n = 1'b0; bus_oe_n = 1'b1;
    @(negedge clk);
    bus_oe_n = 1'b0;
    repeat (hold) @(negedge clk);
    bus_oe_n = 1'b1;
    @(negedge clk);
    bus_ce_n = 1'b1;
  endtask

  task automatic wr(input logic [16:0] a);
    @(negedge clk);
    bus_addr = a; bus_oe_n = 1'b1; bus_ce_n = 1'b0; bus_we_n = 1'b0;
    repeat (2) @(negedge clk);
    bus_ce_n = 1'b1; bus_we_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic send_key(input logic [16:0] hi = '0);
    for (int i = 0; i < 5; i++) rd(hi | {1'b0, key[i]});
  endtask

  task automatic t_reset();
    repeat (2) @(negedge clk);
    chk(auto_store_en == 1'b1, "R1 auto_store_en", auto_store_en, 1);
    chk({store_pls, recall_pls, auto_off_pls, auto_on_pls} == 4'b0,
        "R1 pulses", {store_pls, recall_pls, auto_off_pls, auto_on_pls}, 0);
  endtask

  task automatic t_store_latency();
    snap();
    send_key();
    @(negedge clk);
    bus_addr = {1'b0, A_ST}; bus_ce_n = 1'b0; bus_oe_n = 1'b0;
    @(negedge clk);
    chk(store_pls == 1'b0, "R2 cycle1", store_pls, 0);
    @(negedge clk);
    chk(store_pls == 1'b1, "R2 cycle2", store_pls, 1);
    @(negedge clk);
    chk(store_pls == 1'b0, "R11 width", store_pls, 0);
    bus_ce_n = 1'b1; bus_oe_n = 1'b1;
    expect_cnt("R2", 1, 0, 0, 0);
  endtask

  task automatic t_recall();
    snap(); send_key(); rd({1'b0, A_RC});
    expect_cnt("R3", 0, 1, 0, 0);
  endtask

  task automatic t_auto();
    snap(); send_key(); rd({1'b0, A_OFF});
    expect_cnt("R4 off", 0, 0, 1, 0);
    chk(auto_store_en == 1'b0, "R4 cleared", auto_store_en, 0);
    snap(); send_key(); rd({1'b0, A_ON});
    expect_cnt("R4 on", 0, 0, 0, 1);
    chk(auto_store_en == 1'b1, "R4 set", auto_store_en, 1);
  endtask

  task automatic t_bit16();
    snap(); send_key(17'h10000); rd({1'b1, A_RC});
    expect_cnt("R5", 0, 1, 0, 0);
  endtask

  task automatic t_oe_long();
    snap();
    rd_oe({1'b0, key[0]});
    rd_oe({1'b0, key[1]}, 8);
    rd(    {1'b0, key[2]}, 6);
    rd_oe({1'b0, key[3]});
    rd_oe({1'b0, key[4]});
    rd_oe({1'b0, A_ST});
    expect_cnt("R7", 1, 0, 0, 0);
  endtask

  task automatic t_write_abort();
    snap();
    rd({1'b0, key[0]}); rd({1'b0, key[1]}); rd({1'b0, key[2]});
    wr({1'b0, key[3]});
    rd({1'b0, key[3]}); rd({1'b0, key[4]}); rd({1'b0, A_ST});
    expect_cnt("R6", 0, 0, 0, 0);
  endtask

  task automatic t_restart();
    snap();
    rd({1'b0, key[0]}); rd({1'b0, key[1]});
    send_key(); rd({1'b0, A_RC});
    expect_cnt("R8 restart", 0, 1, 0, 0);
    snap();
    rd({1'b0, key[0]}); rd({1'b0, key[1]}); rd(17'h01234);
    rd({1'b0, key[2]}); rd({1'b0, key[3]}); rd({1'b0, key[4]}); rd({1'b0, A_ST});
    expect_cnt("R8 mismatch", 0, 0, 0, 0);
  endtask

  task automatic t_busy();
    snap();
    rd({1'b0, key[0]}); rd({1'b0, key[1]}); rd({1'b0, key[2]});
    @(negedge clk); seq_busy = 1'b1;
    rd(17'h05555); wr(17'h00000); rd({1'b0, key[0]});
    @(negedge clk); seq_busy = 1'b0;
    rd({1'b0, key[3]}); rd({1'b0, key[4]}); rd({1'b0, A_ST});
    expect_cnt("R9", 1, 0, 0, 0);
  endtask

  task automatic t_idle_after();
    snap();
    rd({1'b0, A_ST});
    expect_cnt("R10 lone", 0, 0, 0, 0);
    snap();
    send_key(); rd(17'h05A5A); rd({1'b0, A_ST});
    expect_cnt("R10 bad6", 0, 0, 0, 0);
    chk(c_multi == 0, "R11 onehot", c_multi, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_store_latency();
    t_recall();
    t_auto();
    t_bit16();
    t_oe_long();
    t_write_abort();
    t_restart();
    t_busy();
    t_idle_after();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule